// File: doc/BRIEF.md
# Transmit Buffer Descriptor Ring Walker

This block steps through a circular list of transmit buffer descriptors kept in shared memory. Each descriptor is four 16-bit words long. The block reads them through a single-port synchronous memory interface. On a poll strobe it reads word 0 of the current descriptor. If the ownership (ready) bit is clear, it goes back to idle. If the bit is set, it reads the length word and the two pointer words. It then presents the 24-bit buffer address, the length and the last-buffer flag to a downstream transmit engine.

The engine reports back through three single-cycle strobes: buffer fetched, frame complete and error. When the strobe that matters for the descriptor arrives, the block writes word 0 back with the ready bit cleared. On the last buffer of a frame, the ten status bits supplied by the engine are also written in. The block then moves to the next descriptor and reads it straight away. The next descriptor is either the ring base or the slot 8 bytes further on. An interrupt pulse can be requested per descriptor.

Word 0 layout, from bit 15 down: ready (15), software ownership (14), wrap (13), interrupt request (12), last (11), host control bit (10), and status (9:0). The status field is: deferred (9), heartbeat (8), late collision (7), retry limit (6), retry count (5:2), underrun (1), carrier lost (0). Word 1 is the length. Word 2 carries pointer bits 23:16 in its low byte. Word 3 carries pointer bits 15:0.

Top module: `txd_ring_walker`

## Requirements
- R1: After reset the block is idle. It issues no memory access, holds `buf_valid_o` and `irq_o` low, and waits for `poll_i`. The first descriptor is at byte address `RING_BASE`.
- R2: A poll in idle reads word 0 of the current descriptor. If bit 15 (ready) is 0, the block returns to idle without writing, stays at the same descriptor, and reads it again only on the next poll.
- R3: With ready = 1, the block reads words 1 to 3. It then holds `buf_valid_o` high with `buf_len_o` = word 1, `buf_ptr_o` = {word2[7:0], word3} and `buf_last_o` = word0 bit 11. Bits 15:8 of word 2 have no effect on any output.
- R4: With last = 0, a fetched strobe releases the descriptor. Word 0 is written as its read value with bit 15 cleared and bits 14:0 unchanged. A frame-complete strobe is ignored.
- R5: With last = 1, a fetched strobe is ignored. A frame-complete strobe releases the descriptor. Word 0 is written with bit 15 = 0, bits 14:10 preserved, and bits 9:0 = `eng_stat_i`.
- R6: An error strobe releases the descriptor in either case. The status field is written from `eng_stat_i` only when last = 1, and left as read when last = 0.
- R7: Only word 0 (byte offset 0 of a descriptor) is ever written. Words 1 to 3, including the ignored high byte of word 2, keep their contents.
- R8: After a release, the next descriptor is `RING_BASE` when the wrap bit (13) was set, and the current address + 8 otherwise. It is read at once, without a poll.
- R9: `irq_o` pulses for exactly the one cycle of the word-0 write, and only when bit 12 of that descriptor is set.
- R10: A poll while a descriptor is being read or handed off has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| poll_i | input | 1 | Start / poll strobe from the host |
| mem_req_o | output | 1 | Memory access this cycle |
| mem_we_o | output | 1 | Access is a write |
| mem_addr_o | output | AW | Byte address of the 16-bit word |
| mem_wdata_o | output | 16 | Write data (word 0 writeback) |
| mem_rdata_i | input | 16 | Read data, valid the cycle after a read request |
| buf_valid_o | output | 1 | Buffer handed to the transmit engine |
| buf_ptr_o | output | 24 | Buffer start address |
| buf_len_o | output | 16 | Buffer length |
| buf_last_o | output | 1 | Buffer is the last of its frame |
| eng_fetched_i | input | 1 | Engine has moved the whole buffer |
| eng_done_i | input | 1 | Engine has finished transmitting the frame |
| eng_err_i | input | 1 | Engine aborted on an error |
| eng_stat_i | input | 10 | Status bits for word 0 bits 9:0 |
| irq_o | output | 1 | One-cycle interrupt pulse |

## Verification
The table drives six descriptors around a four-slot ring. The set covers both values of the last flag and all three engine outcomes, so releases with and without status merging are told apart. The ownership and host bits are varied from one descriptor to the next, and each descriptor first receives the strobe that its last flag says to ignore, which separates R4 from R5. The fourth slot carries the wrap bit and the table continues past it, so a wrap back to the base shows up in the next read address. Directed tests then poll a slot whose ready bit is clear and poll again during a handoff.

// File: rtl/txd_pkg.sv
package txd_pkg;

  localparam int WORD_W = 16;
  localparam int STAT_W = 10;
  localparam int PTR_W  = 24;

  // word 0 bit positions
  localparam int B_RDY  = 15;
  localparam int B_WRAP = 13;
  localparam int B_IRQ  = 12;
  localparam int B_LAST = 11;

  typedef enum logic [2:0] {
    WK_IDLE,
    WK_RD0,
    WK_W0,
    WK_W1,
    WK_W2,
    WK_W3,
    WK_HAND,
    WK_WB
  } walk_st_e;

  // writeback image of word 0: ready cleared, host bits kept, status merged on last
  function automatic logic [WORD_W-1:0] wb_word(input logic [WORD_W-1:0] w0,
                                                input logic [STAT_W-1:0] st);
    logic [WORD_W-1:0] r;
    r = w0;
    r[B_RDY] = 1'b0;
    if (w0[B_LAST]) r[STAT_W-1:0] = st;
    return r;
  endfunction

  function automatic logic [PTR_W-1:0] join_ptr(input logic [7:0] hi,
                                               input logic [WORD_W-1:0] lo);
    return {hi, lo};
  endfunction

  // release condition for a descriptor in handoff
  function automatic logic rel_now(input logic last, input logic fetched,
                                   input logic done, input logic err);
    return err | (last ? done : fetched);
  endfunction

endpackage

// File: rtl/txd_ring_ptr.sv
module txd_ring_ptr #(
  parameter int          AW        = 16,
  parameter logic [AW-1:0] RING_BASE = 'h40,
  parameter int          STEP      = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          adv_i,
  input  logic          wrap_i,
  output logic [AW-1:0] cur_o
);
  localparam logic [AW-1:0] STEP_W = AW'(STEP);

  function automatic logic [AW-1:0] next_slot(input logic [AW-1:0] cur, input logic wrap);
    return wrap ? RING_BASE : cur + STEP_W;
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n)     cur_o <= RING_BASE;
    else if (adv_i) cur_o <= next_slot(cur_o, wrap_i);
  end
endmodule

// File: rtl/txd_walk_fsm.sv
module txd_walk_fsm
  import txd_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                poll_i,
  input  logic [WORD_W-1:0]   rdata_i,
  input  logic                eng_fetched_i,
  input  logic                eng_done_i,
  input  logic                eng_err_i,
  input  logic [STAT_W-1:0]   eng_stat_i,
  output walk_st_e            st_o,
  output logic [WORD_W-1:0]   w0_o,
  output logic [WORD_W-1:0]   len_o,
  output logic [PTR_W-1:0]    ptr_o,
  output logic [STAT_W-1:0]   stat_o,
  output logic                release_o,
  output logic                idle_o
);
  walk_st_e          st_q;
  logic [WORD_W-1:0] w0_q, len_q, lo_q;
  logic [7:0]        hi_q;
  logic [STAT_W-1:0] stat_q;
  logic              rel;

  assign rel = (st_q == WK_HAND) &&
               rel_now(w0_q[B_LAST], eng_fetched_i, eng_done_i, eng_err_i);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q   <= WK_IDLE;
      w0_q   <= '0;
      len_q  <= '0;
      hi_q   <= '0;
      lo_q   <= '0;
      stat_q <= '0;
    end else begin
      case (st_q)
        WK_IDLE: if (poll_i) st_q <= WK_RD0;
        WK_RD0:  st_q <= WK_W0;
        WK_W0: begin
          w0_q <= rdata_i;
          st_q <= rdata_i[B_RDY] ? WK_W1 : WK_IDLE;
        end
        WK_W1: begin
          len_q <= rdata_i;
          st_q  <= WK_W2;
        end
        WK_W2: begin
          hi_q <= rdata_i[7:0];
          st_q <= WK_W3;
        end
        WK_W3: begin
          lo_q <= rdata_i;
          st_q <= WK_HAND;
        end
        WK_HAND: if (rel) begin
          stat_q <= eng_stat_i;
          st_q   <= WK_WB;
        end
        WK_WB:   st_q <= WK_RD0;
        default: st_q <= WK_IDLE;
      endcase
    end
  end

  assign st_o      = st_q;
  assign w0_o      = w0_q;
  assign len_o     = len_q;
  assign ptr_o     = join_ptr(hi_q, lo_q);
  assign stat_o    = stat_q;
  assign release_o = rel;
  assign idle_o    = (st_q == WK_IDLE);
endmodule

// File: rtl/txd_ring_walker.sv
module txd_ring_walker
  import txd_pkg::*;
#(
  parameter int            AW        = 16,
  parameter logic [AW-1:0] RING_BASE = 'h40,
  parameter int            DESC_BYTES = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          poll_i,
  output logic          mem_req_o,
  output logic          mem_we_o,
  output logic [AW-1:0] mem_addr_o,
  output logic [15:0]   mem_wdata_o,
  input  logic [15:0]   mem_rdata_i,
  output logic          buf_valid_o,
  output logic [23:0]   buf_ptr_o,
  output logic [15:0]   buf_len_o,
  output logic          buf_last_o,
  input  logic          eng_fetched_i,
  input  logic          eng_done_i,
  input  logic          eng_err_i,
  input  logic [9:0]    eng_stat_i,
  output logic          irq_o
);
  walk_st_e          st;
  logic [WORD_W-1:0] w0;
  logic [STAT_W-1:0] stat;
  logic [AW-1:0]     cur;
  logic [AW-1:0]     ofs;
  logic              desc_release;
  logic              walk_idle;
  logic              wb_cycle;

  txd_walk_fsm fsm_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .poll_i       (poll_i),
    .rdata_i      (mem_rdata_i),
    .eng_fetched_i(eng_fetched_i),
    .eng_done_i   (eng_done_i),
    .eng_err_i    (eng_err_i),
    .eng_stat_i   (eng_stat_i),
    .st_o         (st),
    .w0_o         (w0),
    .len_o        (buf_len_o),
    .ptr_o        (buf_ptr_o),
    .stat_o       (stat),
    .release_o    (desc_release),
    .idle_o       (walk_idle)
  );

  assign wb_cycle = (st == WK_WB);

  txd_ring_ptr #(.AW(AW), .RING_BASE(RING_BASE), .STEP(DESC_BYTES)) ptr_i (
    .clk   (clk),
    .rst_n (rst_n),
    .adv_i (wb_cycle),
    .wrap_i(w0[B_WRAP]),
    .cur_o (cur)
  );

  always_comb begin
    case (st)
      WK_W0:   ofs = AW'(2);
      WK_W1:   ofs = AW'(4);
      WK_W2:   ofs = AW'(6);
      default: ofs = '0;
    endcase
  end

  assign mem_req_o   = (st == WK_RD0) || (st == WK_W0 && mem_rdata_i[B_RDY]) ||
                       (st == WK_W1) || (st == WK_W2) || wb_cycle;
  assign mem_we_o    = wb_cycle;
  assign mem_addr_o  = cur + ofs;
  assign mem_wdata_o = wb_word(w0, stat);
  assign buf_valid_o = (st == WK_HAND);
  assign buf_last_o  = w0[B_LAST];
  assign irq_o       = wb_cycle && w0[B_IRQ];
endmodule

// File: rtl/txd_ring_walker_chk.sv
module txd_ring_walker_chk #(
  parameter int AW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          mem_req_o,
  input logic          mem_we_o,
  input logic [AW-1:0] mem_addr_o,
  input logic [15:0]   mem_wdata_o,
  input logic          buf_valid_o,
  input logic [23:0]   buf_ptr_o,
  input logic [15:0]   buf_len_o,
  input logic          irq_o,
  input logic          walk_idle,
  input logic          desc_release
);
  // R1
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    walk_idle |-> !mem_req_o && !buf_valid_o && !irq_o);
  // R7
  wb_word0_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_o && mem_we_o) |-> mem_addr_o[2:0] == 3'd0);
  // R4
  wb_ready_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_o && mem_we_o) |-> !mem_wdata_o[15]);
  // R5
  release_then_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    desc_release |=> mem_req_o && mem_we_o);
  // R9
  irq_on_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> mem_req_o && mem_we_o);
  // R9
  irq_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |=> !irq_o);
  // R3
  hand_no_mem_chk: assert property (@(posedge clk) disable iff (!rst_n)
    buf_valid_o |-> !mem_req_o);
  // R3
  hand_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (buf_valid_o && $past(buf_valid_o)) |-> $stable(buf_ptr_o) && $stable(buf_len_o));
endmodule

bind txd_ring_walker txd_ring_walker_chk #(.AW(AW)) chk_i (
  .clk         (clk),
  .rst_n       (rst_n),
  .mem_req_o   (mem_req_o),
  .mem_we_o    (mem_we_o),
  .mem_addr_o  (mem_addr_o),
  .mem_wdata_o (mem_wdata_o),
  .buf_valid_o (buf_valid_o),
  .buf_ptr_o   (buf_ptr_o),
  .buf_len_o   (buf_len_o),
  .irq_o       (irq_o),
  .walk_idle   (walk_idle),
  .desc_release(desc_release)
);

// File: tb/txd_ring_walker_tb.sv
module txd_ring_walker_tb_top;
  localparam int AW = 16;
  localparam logic [AW-1:0] BASE = 16'h0040;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic poll_i = 1'b0;
  logic mem_req_o, mem_we_o;
  logic [AW-1:0] mem_addr_o;
  logic [15:0] mem_wdata_o;
  logic [15:0] mem_rdata_i = '0;
  logic buf_valid_o, buf_last_o, irq_o;
  logic [23:0] buf_ptr_o;
  logic [15:0] buf_len_o;
  logic eng_fetched_i = 1'b0, eng_done_i = 1'b0, eng_err_i = 1'b0;
  logic [9:0] eng_stat_i = '0;

  always #2.5 clk = ~clk;

  txd_ring_walker #(.AW(AW), .RING_BASE(BASE)) dut_i (.*);

  // memory model and port monitor
  logic [15:0] mem [0:63];
  int wr_cnt = 0, rd_cnt = 0, irq_cnt = 0;
  logic [AW-1:0] last_wr_addr = '0, last_rd_addr = '0;
  logic [15:0] last_wr_data = '0;
  logic irq_at_wr = 1'b0;

  always @(posedge clk) begin
    if (irq_o) irq_cnt <= irq_cnt + 1;
    if (rst_n && mem_req_o) begin
      if (mem_we_o) begin
        mem[mem_addr_o[6:1]] <= mem_wdata_o;
        wr_cnt <= wr_cnt + 1;
        last_wr_addr <= mem_addr_o;
        last_wr_data <= mem_wdata_o;
        irq_at_wr <= irq_o;
      end else begin
        mem_rdata_i <= mem[mem_addr_o[6:1]];
        rd_cnt <= rd_cnt + 1;
        last_rd_addr <= mem_addr_o;
      end
    end
  end

  int n_chk = 0, n_fail = 0;

  task automatic chk(input bit ok, input string rq, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", rq, act, exp);
    end
  endtask

  task automatic report();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  int cyc = 0;
  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 50000) begin
      n_fail++;
      n_chk++;
      $display("FAIL watchdog actual=%0d expected=<50000", cyc);
      report();
    end
  end

  // to,w,i,l,tc, old status(10), len(16), ptr(24), junk hi byte(8), act(2: 0 fetched,1 done,2 err), stat(10)
  localparam int VW = 75;
  localparam int NV = 6;
  localparam logic [VW-1:0] VECS [NV] = '{
    {1'b0,1'b0,1'b1,1'b0,1'b0,10'h2A5,16'd64,   24'h123456,8'hA5,2'd0,10'h3FF},
    {1'b1,1'b0,1'b0,1'b1,1'b1,10'h000,16'd1518, 24'hABCDEF,8'h5A,2'd1,10'h3C3},
    {1'b0,1'b0,1'b1,1'b1,1'b0,10'h3FF,16'd1,    24'h00FFFE,8'hFF,2'd2,10'h155},
    {1'b1,1'b1,1'b0,1'b0,1'b1,10'h155,16'd300,  24'h800000,8'h00,2'd2,10'h2AA},
    {1'b1,1'b0,1'b1,1'b1,1'b0,10'h1E0,16'd60,   24'h7F0102,8'hC3,2'd1,10'h0FF},
    {1'b0,1'b0,1'b0,1'b0,1'b0,10'h000,16'd65535,24'hFFFFFF,8'h3C,2'd0,10'h111}
  };

  task automatic pulse_poll();
    @(negedge clk) poll_i = 1'b1;
    @(negedge clk) poll_i = 1'b0;
  endtask

  task automatic pulse_eng(input logic [1:0] act, input logic [9:0] st);
    @(negedge clk);
    eng_fetched_i = (act == 2'd0);
    eng_done_i    = (act == 2'd1);
    eng_err_i     = (act == 2'd2);
    eng_stat_i    = st;
    @(negedge clk);
    eng_fetched_i = 1'b0; eng_done_i = 1'b0; eng_err_i = 1'b0; eng_stat_i = '0;
  endtask

  task automatic wait_valid();
    for (int k = 0; k < 20 && !buf_valid_o; k++) @(negedge clk);
  endtask

  task automatic load_desc(input logic [AW-1:0] a, input logic [15:0] w0, input logic [15:0] len,
                           input logic [7:0] junk, input logic [23:0] ptr);
    mem[a[6:1]]     = w0;
    mem[a[6:1] + 1] = len;
    mem[a[6:1] + 2] = {junk, ptr[23:16]};
    mem[a[6:1] + 3] = ptr[15:0];
  endtask

  logic [AW-1:0] exp_addr;

  initial begin
    for (int k = 0; k < 64; k++) mem[k] = '0;
    exp_addr = BASE;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    // R1 reset state
    chk(rd_cnt == 0 && wr_cnt == 0, "R1 no access", rd_cnt + wr_cnt, 0);
    chk(!buf_valid_o, "R1 valid", buf_valid_o, 0);
    chk(irq_cnt == 0 && !irq_o, "R1 irq", irq_cnt, 0);

    for (int v = 0; v < NV; v++) begin
      logic [VW-1:0] e;
      logic to, w, i, l, tc;
      logic [9:0] old, st;
      logic [15:0] len, w0, exp_w0;
      logic [23:0] ptr;
      logic [7:0] junk;
      logic [1:0] act;
      logic [AW-1:0] nxt;
      int wr0;
      string rq;
      e = VECS[v];
      {to, w, i, l, tc, old, len, ptr, junk, act, st} = e;
      w0 = {1'b1, to, w, i, l, tc, old};
      nxt = w ? BASE : exp_addr + 16'd8;
      @(negedge clk);
      load_desc(exp_addr, w0, len, junk, ptr);
      mem[nxt[6:1]] = 16'h0000;
      pulse_poll();
      wait_valid();
      // R3 handoff fields
      chk(buf_valid_o, "R3 valid", buf_valid_o, 1);
      chk(buf_ptr_o == ptr, "R3 ptr", buf_ptr_o, ptr);
      chk(buf_len_o == len, "R3 len", buf_len_o, len);
      chk(buf_last_o == l, "R3 last", buf_last_o, l);
      // the strobe this descriptor must ignore
      wr0 = wr_cnt;
      pulse_eng(l ? 2'd0 : 2'd1, 10'h2DB);
      repeat (3) @(negedge clk);
      rq = l ? "R5 fetched ignored" : "R4 done ignored";
      chk(wr_cnt == wr0 && buf_valid_o, rq, wr_cnt, wr0);
      pulse_eng(act, st);
      for (int k = 0; k < 6 && wr_cnt == wr0; k++) @(negedge clk);
      exp_w0 = {1'b0, to, w, i, l, tc, l ? st : old};
      rq = (act == 2'd2) ? "R6 writeback" : (l ? "R5 writeback" : "R4 writeback");
      chk(wr_cnt == wr0 + 1, rq, wr_cnt, wr0 + 1);
      chk(last_wr_data == exp_w0, rq, last_wr_data, exp_w0);
      chk(last_wr_addr == exp_addr, "R7 write addr", last_wr_addr, exp_addr);
      chk(irq_at_wr == i, "R9 irq at write", irq_at_wr, i);
      repeat (4) @(negedge clk);
      chk(last_rd_addr == nxt, "R8 next slot", last_rd_addr, nxt);
      chk(mem[exp_addr[6:1] + 2] == {junk, ptr[23:16]}, "R7 word2 kept",
          mem[exp_addr[6:1] + 2], {junk, ptr[23:16]});
      chk(!buf_valid_o && !irq_o, "R2 idle after R=0", buf_valid_o, 0);
      exp_addr = nxt;
    end
    chk(irq_cnt == 3, "R9 irq count", irq_cnt, 3);

    // R2: poll on a not-ready slot
    begin
      int r0, w0c;
      r0 = rd_cnt; w0c = wr_cnt;
      pulse_poll();
      repeat (6) @(negedge clk);
      chk(rd_cnt == r0 + 1, "R2 single read", rd_cnt, r0 + 1);
      chk(last_rd_addr == exp_addr, "R2 same slot", last_rd_addr, exp_addr);
      chk(wr_cnt == w0c && !buf_valid_o, "R2 no write", wr_cnt, w0c);
      repeat (6) @(negedge clk);
      chk(rd_cnt == r0 + 1, "R2 waits for poll", rd_cnt, r0 + 1);
    end

    // R10: poll during handoff
    begin
      int r0;
      load_desc(exp_addr, 16'h8000, 16'd99, 8'h11, 24'h445566);
      mem[exp_addr[6:1] + 4] = 16'h0000;
      pulse_poll();
      wait_valid();
      r0 = rd_cnt;
      pulse_poll();
      repeat (3) @(negedge clk);
      chk(rd_cnt == r0, "R10 no read", rd_cnt, r0);
      chk(buf_valid_o && buf_ptr_o == 24'h445566, "R10 handoff kept", buf_ptr_o, 24'h445566);
      pulse_eng(2'd0, 10'h000);
      repeat (4) @(negedge clk);
      chk(mem[exp_addr[6:1]] == 16'h0000, "R4 released", mem[exp_addr[6:1]], 16'h0000);
    end

    report();
  end
endmodule